// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a device among four operating modes (Active, Power Save, Idle and Halt) under the control of one byte-wide control/status register. Software writes the register to ask for a lower-power mode. The request takes effect in one of two ways. With the defer bit clear it takes effect at once. With the defer bit set it waits for the next WAIT-instruction strobe. A hardware wake-up event clears the request bits and brings the block back to Active.

Each move is gated by two clock-stability flags, which the register also shows. The block leaves Active for Power Save or Idle only while the slow clock is stable. It returns to Active only while the fast clock is stable. When a wake-up finds the fast oscillator stopped, the block turns the oscillator back on and stays in an internal waking state on the slow clock until the fast clock reports stable. The block drives the fast-oscillator enable, the fast/slow system clock select and a clock-gate enable that is low in Halt.

A wake-up only restores the mode and the clocks. Resuming program execution is left to the interrupt logic around the block.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the low six register bits read 0, the mode output is Active (code 0), the fast oscillator is enabled, the fast clock is selected and the clock gate is open.
- R2: Register bit 7 reads the slow-clock-stable input and bit 6 reads the fast-clock-stable input. Writes to bits 7, 6 and 4 have no effect, and bit 4 always reads 0.
- R3: Writing bit 0 (power-save request) as 1 with bit 5 (defer) as 0 while in Active starts an immediate switch. Bit 0 still reads 0 in the cycle after the write. One cycle later the mode reads Power Save (code 1) and bit 0 reads 1.
- R4: Writing bit 0 as 1 with bit 5 as 1 makes bit 0 read 1 in the cycle after the write. The mode stays Active until a WAIT strobe, which then enters Power Save.
- R5: In Power Save, a WAIT strobe with bit 2 set enters Idle (code 2). In Idle, a WAIT strobe with bit 3 set enters Halt (code 3).
- R6: A WAIT strobe in Active acts only when bit 5 is set. It then picks Halt (bit 3) before Idle (bit 2) before Power Save (bit 0). With bit 5 clear, or with none of those bits set, the mode stays Active and the register is unchanged.
- R7: The fast oscillator is enabled in Active and disabled in Halt. In Power Save and Idle its enable is the inverse of bit 1 (oscillator-off).
- R8: A wake-up event clears bits 3, 2, 1 and 0 at the next edge, leaves bit 5 unchanged and takes priority over a write in the same cycle.
- R9: On a wake-up from Power Save, Idle or Halt, the block enters Active at the next edge if the fast clock is stable. Otherwise it waits with the oscillator enabled, the slow clock selected and the mode reading Power Save until the fast-stable input is 1, and enters Active at the edge after that.
- R10: The block leaves Active for Power Save or Idle only while the slow-clock-stable input is 1. A request made while it is 0 is held for the immediate case and dropped for the WAIT case. Entry to Halt has no such condition.
- R11: Clearing bit 0 by a write while in Power Save returns the block to Active one cycle after bit 0 reads 0.
- R12: The fast clock is selected only in Active. The clock-gate enable is low only in Halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| wait_stb | input | 1 | One-cycle WAIT-instruction strobe |
| wake_evt | input | 1 | Hardware wake-up event |
| fast_stable | input | 1 | Fast clock running and stable |
| slow_stable | input | 1 | Slow clock running and stable |
| mode_o | output | 2 | Reported mode: 0 Active, 1 Power Save, 2 Idle, 3 Halt |
| fast_osc_en | output | 1 | Fast oscillator enable |
| clk_sel_fast | output | 1 | 1 selects the fast system clock, 0 the slow one |
| clk_gate_en | output | 1 | Gated-clock enable, low in Halt |

## Verification
Register bits written by software, and the bits cleared by a wake-up, are due one edge after the strobe. The bench drives each strobe at a falling edge and reads the result at the next falling edge. Mode changes from a WAIT strobe, a wake-up or a software clear of the request bit also appear one edge after their cause. The immediate power-save switch passes through a request flop, so the bench waits one further edge before it expects Power Save and a set request bit. The clock outputs decode the registered state without delay, and the stability flags in the register are sampled with no synchronizer stages at the default setting, so those checks use the same falling-edge sample point.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int REG_W = 8;
   localparam int MODE_W = 2;

   // register bit positions
   localparam int B_SLOW  = 7;
   localparam int B_FAST  = 6;
   localparam int B_DEFER = 5;
   localparam int B_RSVD  = 4;
   localparam int B_HALT  = 3;
   localparam int B_IDLE  = 2;
   localparam int B_OSCOFF = 1;
   localparam int B_PSREQ = 0;

   localparam logic [MODE_W-1:0] MODE_ACTIVE = 2'd0;
   localparam logic [MODE_W-1:0] MODE_PS     = 2'd1;
   localparam logic [MODE_W-1:0] MODE_IDLE   = 2'd2;
   localparam logic [MODE_W-1:0] MODE_HALT   = 2'd3;

   typedef enum logic [2:0] {
      ST_ACTIVE = 3'd0,
      ST_PS     = 3'd1,
      ST_IDLE   = 3'd2,
      ST_HALT   = 3'd3,
      ST_WAKE   = 3'd4
   } pm_state_e;
endpackage

// File: rtl/pmc_flag_sync.sv
module pmc_flag_sync #(
   parameter int STAGES = 0,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("pmc_flag_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_pipe
         logic [W-1:0] pipe [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_st
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[i] <= '0;
               else if (i == 0) pipe[i] <= d;
               else pipe[i] <= pipe[(i == 0) ? 0 : i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
   import pmc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   input  logic             wake,
   input  logic             in_active,
   input  logic             enter_ps,
   input  logic             fast_ok,
   input  logic             slow_ok,
   output logic             defer_q,
   output logic             halt_q,
   output logic             idle_q,
   output logic             oscoff_q,
   output logic             psreq_q,
   output logic             imm_req_q,
   output logic [REG_W-1:0] rdata
);
   logic unused_wbits;
   assign unused_wbits = ^{wdata[B_SLOW], wdata[B_FAST], wdata[B_RSVD]};

   logic wr_ps, wr_defer;
   assign wr_ps    = wdata[B_PSREQ];
   assign wr_defer = wdata[B_DEFER];

   // software-owned bits; wake clears all but defer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         defer_q  <= 1'b0;
         halt_q   <= 1'b0;
         idle_q   <= 1'b0;
         oscoff_q <= 1'b0;
      end else begin
         if (we) defer_q <= wr_defer;
         if (wake) begin
            halt_q   <= 1'b0;
            idle_q   <= 1'b0;
            oscoff_q <= 1'b0;
         end else if (we) begin
            halt_q   <= wdata[B_HALT];
            idle_q   <= wdata[B_IDLE];
            oscoff_q <= wdata[B_OSCOFF];
         end
      end
   end

   // power-save bit: immediate form reads 1 only once the switch is done
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psreq_q   <= 1'b0;
         imm_req_q <= 1'b0;
      end else if (wake) begin
         psreq_q   <= 1'b0;
         imm_req_q <= 1'b0;
      end else if (enter_ps) begin
         psreq_q   <= 1'b1;
         imm_req_q <= 1'b0;
      end else if (we) begin
         if (!wr_ps) begin
            psreq_q   <= 1'b0;
            imm_req_q <= 1'b0;
         end else if (wr_defer) begin
            psreq_q   <= 1'b1;
         end else if (in_active) begin
            imm_req_q <= 1'b1;
         end
      end
   end

   always_comb begin
      rdata           = '0;
      rdata[B_SLOW]   = slow_ok;
      rdata[B_FAST]   = fast_ok;
      rdata[B_DEFER]  = defer_q;
      rdata[B_HALT]   = halt_q;
      rdata[B_IDLE]   = idle_q;
      rdata[B_OSCOFF] = oscoff_q;
      rdata[B_PSREQ]  = psreq_q;
   end

   p_defer_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wr_ps && wr_defer && !wake) |=> psreq_q)
      else $error("p_defer_set_r4");
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
   import pmc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wait_i,
   input  logic      wake_i,
   input  logic      fast_ok,
   input  logic      slow_ok,
   input  logic      defer,
   input  logic      halt,
   input  logic      idle,
   input  logic      psreq,
   input  logic      imm_req,
   output pm_state_e state_o,
   output logic      enter_ps_o
);
   pm_state_e state_q, state_d, wake_tgt;

   assign wake_tgt = fast_ok ? ST_ACTIVE : ST_WAKE;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_ACTIVE: begin
            if (wake_i) state_d = ST_ACTIVE;
            else if (wait_i && defer && (halt || idle || psreq)) begin
               if (halt) state_d = ST_HALT;
               else if (idle) state_d = slow_ok ? ST_IDLE : ST_ACTIVE;
               else state_d = slow_ok ? ST_PS : ST_ACTIVE;
            end else if (imm_req && slow_ok) state_d = ST_PS;
         end
         ST_PS: begin
            if (wake_i || !psreq) state_d = wake_tgt;
            else if (wait_i && idle) state_d = ST_IDLE;
         end
         ST_IDLE: begin
            if (wake_i) state_d = wake_tgt;
            else if (wait_i && halt) state_d = ST_HALT;
         end
         ST_HALT: begin
            if (wake_i) state_d = wake_tgt;
         end
         ST_WAKE: begin
            if (fast_ok) state_d = ST_ACTIVE;
         end
         default: state_d = ST_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_ACTIVE;
      else state_q <= state_d;
   end

   assign state_o    = state_q;
   assign enter_ps_o = (state_d == ST_PS) && (state_q != ST_PS);

   p_enter_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_ACTIVE && !fast_ok) |=> state_q != ST_ACTIVE)
      else $error("p_enter_active_r9");
   p_waking_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAKE && !fast_ok) |=> state_q == ST_WAKE)
      else $error("p_waking_hold_r9");
   p_leave_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACTIVE && !slow_ok) |=> (state_q == ST_ACTIVE || state_q == ST_HALT))
      else $error("p_leave_active_r10");
   p_wait_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PS && wait_i && idle && psreq && !wake_i) |=> state_q == ST_IDLE)
      else $error("p_wait_idle_r5");
endmodule

// File: rtl/pmc_clk_ctl.sv
module pmc_clk_ctl
   import pmc_pkg::*;
(
   input  pm_state_e         state,
   input  logic              oscoff,
   output logic [MODE_W-1:0] mode,
   output logic              osc_en,
   output logic              sel_fast,
   output logic              gate_en
);
   always_comb begin
      mode     = MODE_ACTIVE;
      osc_en   = 1'b1;
      sel_fast = 1'b0;
      gate_en  = 1'b1;
      unique case (state)
         ST_ACTIVE: sel_fast = 1'b1;
         ST_PS:     begin mode = MODE_PS;   osc_en = !oscoff; end
         ST_IDLE:   begin mode = MODE_IDLE; osc_en = !oscoff; end
         ST_HALT:   begin mode = MODE_HALT; osc_en = 1'b0; gate_en = 1'b0; end
         ST_WAKE:   mode = MODE_PS;
         default:   mode = MODE_ACTIVE;
      endcase
   end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
   import pmc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              wait_stb,
   input  logic              wake_evt,
   input  logic              fast_stable,
   input  logic              slow_stable,
   output logic [MODE_W-1:0] mode_o,
   output logic              fast_osc_en,
   output logic              clk_sel_fast,
   output logic              clk_gate_en
);
   localparam int FLAG_W = 2;

   generate
      if (DATA_W != REG_W) begin : g_bad_w
         $error("pwr_mode_ctl: DATA_W must equal REG_W");
      end
   endgenerate

   logic [FLAG_W-1:0] flags;
   logic fast_ok, slow_ok;
   logic defer_q, halt_q, idle_q, oscoff_q, psreq_q, imm_req_q, enter_ps;
   pm_state_e state;

   pmc_flag_sync #(.STAGES(SYNC_STAGES), .W(FLAG_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({slow_stable, fast_stable}), .q(flags));
   assign slow_ok = flags[1];
   assign fast_ok = flags[0];

   pmc_ctrl_reg u_reg (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .wake(wake_evt),
      .in_active(state == ST_ACTIVE), .enter_ps(enter_ps),
      .fast_ok(fast_ok), .slow_ok(slow_ok),
      .defer_q(defer_q), .halt_q(halt_q), .idle_q(idle_q), .oscoff_q(oscoff_q),
      .psreq_q(psreq_q), .imm_req_q(imm_req_q), .rdata(reg_rdata));

   pmc_mode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .wait_i(wait_stb), .wake_i(wake_evt),
      .fast_ok(fast_ok), .slow_ok(slow_ok), .defer(defer_q), .halt(halt_q),
      .idle(idle_q), .psreq(psreq_q), .imm_req(imm_req_q),
      .state_o(state), .enter_ps_o(enter_ps));

   pmc_clk_ctl u_clk (
      .state(state), .oscoff(oscoff_q), .mode(mode_o), .osc_en(fast_osc_en),
      .sel_fast(clk_sel_fast), .gate_en(clk_gate_en));

   p_wake_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |=> reg_rdata[3:0] == 4'h0)
      else $error("p_wake_clears_r8");
   p_halt_osc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_HALT) |-> (!fast_osc_en && !clk_gate_en))
      else $error("p_halt_osc_r7");
   p_sel_fast_r12: assert property (@(posedge clk) disable iff (!rst_n)
      clk_sel_fast |-> (mode_o == MODE_ACTIVE && fast_osc_en))
      else $error("p_sel_fast_r12");
endmodule

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic wait_stb = 1'b0;
   logic wake_evt = 1'b0;
   logic fast_stable = 1'b1;
   logic slow_stable = 1'b1;
   logic [1:0] mode_o;
   logic fast_osc_en, clk_sel_fast, clk_gate_en;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwr_mode_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .wait_stb(wait_stb), .wake_evt(wake_evt),
      .fast_stable(fast_stable), .slow_stable(slow_stable), .mode_o(mode_o),
      .fast_osc_en(fast_osc_en), .clk_sel_fast(clk_sel_fast), .clk_gate_en(clk_gate_en));

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [7:0] d);
      reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic pulse_wait();
      wait_stb = 1'b1;
      @(negedge clk);
      wait_stb = 1'b0;
   endtask

   task automatic pulse_wake();
      wake_evt = 1'b1;
      @(negedge clk);
      wake_evt = 1'b0;
   endtask

   // {gate, sel, osc, 3'b0, mode}
   function automatic logic [7:0] outs();
      return {clk_gate_en, clk_sel_fast, fast_osc_en, 3'b000, mode_o};
   endfunction

   task automatic t_reset();
      check("R1 rdata", reg_rdata, 8'hC0);
      check("R1 outputs", outs(), 8'hE0);
   endtask

   task automatic t_ro_bits();
      wr(8'hD0);
      check("R2 ro bits ignored", reg_rdata, 8'hC0);
      slow_stable = 1'b0;
      step(1);
      check("R2 bit7 tracks slow", reg_rdata, 8'h40);
      slow_stable = 1'b1;
      step(1);
   endtask

   task automatic t_immediate();
      wr(8'h01);
      check("R3 psm not yet set", reg_rdata, 8'hC0);
      check("R3 still active", outs(), 8'hE0);
      step(1);
      check("R3 psm after switch", reg_rdata, 8'hC1);
      check("R12 power save outputs", outs(), 8'hA1);
      wr(8'h00);
      check("R11 psm cleared", reg_rdata, 8'hC0);
      step(1);
      check("R11 back to active", outs(), 8'hE0);
   endtask

   task automatic t_oscoff_wake();
      wr(8'h03);
      step(1);
      check("R7 osc off in power save", outs(), 8'h81);
      fast_stable = 1'b0;
      pulse_wake();
      check("R8 wake clears bits", reg_rdata, 8'h80);
      check("R9 waking outputs", outs(), 8'hA1);
      step(3);
      check("R9 waking holds", outs(), 8'hA1);
      fast_stable = 1'b1;
      step(1);
      check("R9 active after fast stable", outs(), 8'hE0);
   endtask

   task automatic t_deferred();
      wr(8'h21);
      check("R4 psm reads 1 at once", reg_rdata, 8'hE1);
      step(2);
      check("R4 stays active before wait", outs(), 8'hE0);
      pulse_wait();
      check("R4 power save after wait", outs(), 8'hA1);
      wr(8'h25);
      pulse_wait();
      check("R5 idle from power save", outs(), 8'hA2);
      wr(8'h2D);
      pulse_wait();
      check("R5 halt from idle", outs(), 8'h03);
      pulse_wake();
      check("R9 direct active with fast stable", outs(), 8'hE0);
      check("R8 defer kept", reg_rdata, 8'hE0);
   endtask

   task automatic t_priority();
      wr(8'h2D);
      pulse_wait();
      check("R6 halt first", outs(), 8'h03);
      pulse_wake();
      wr(8'h25);
      pulse_wait();
      check("R6 idle second", outs(), 8'hA2);
      pulse_wake();
      wr(8'h21);
      pulse_wait();
      check("R6 power save third", outs(), 8'hA1);
      pulse_wake();
      wr(8'h20);
      pulse_wait();
      check("R6 none set stays active", outs(), 8'hE0);
      wr(8'h0C);
      pulse_wait();
      check("R6 no defer stays active", outs(), 8'hE0);
      check("R6 register unchanged", reg_rdata, 8'hCC);
      pulse_wake();
   endtask

   task automatic t_slow_gate();
      slow_stable = 1'b0;
      wr(8'h01);
      step(3);
      check("R10 no power save without slow", outs(), 8'hE0);
      check("R10 psm still 0", reg_rdata, 8'h40);
      wr(8'h24);
      pulse_wait();
      check("R10 no idle without slow", outs(), 8'hE0);
      wr(8'h28);
      pulse_wait();
      check("R10 halt without slow", outs(), 8'h03);
      pulse_wake();
      check("R10 wake from halt", outs(), 8'hE0);
      slow_stable = 1'b1;
      step(1);
   endtask

   task automatic t_wake_priority();
      wake_evt = 1'b1;
      wr(8'h0E);
      wake_evt = 1'b0;
      check("R8 wake beats write", reg_rdata, 8'hC0);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_ro_bits();
      t_immediate();
      t_oscoff_wake();
      t_deferred();
      t_priority();
      t_slow_gate();
      t_wake_priority();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule